// File: doc/BRIEF.md
# Synchronizable Time-Tag Counter Unit

This unit keeps a free-running 16-bit time-tag count for one remote terminal on a serial command/response bus. The count advances on each cycle where a tick enable is high and rolls over from 0xFFFF to 0x0000. Two decoded mode-command strobes resynchronise the count: one strobe carries no data word, the other carries one. The data-bearing command is filtered by a 2-bit option field. When the command is addressed to this terminal alone, the unit releases the status word only after the counter has taken its new value.

The host owns a 16-bit utility register. That register is the source for host-requested loads and the target for host-requested captures. It is also the compare value for a count-match interrupt. A 2-bit action field starts a host action, and it reads back as idle once the action is done. A master reset clears everything. The terminal soft reset clears the count and any pending work, but keeps the utility register.

Top module: `ttag_unit`

## Requirements
- R1: After master reset (rst_n low): count, util_q, act_q, match_irq and stat_release are all zero.
- R2: With no other event in a cycle, tick_en high increments count on the next clock edge. 0xFFFF is followed by 0x0000.
- R3: A sync_nodata_stb clears count to 0x0000 on the next edge, whatever the tick or host action.
- R4: On sync_data_stb with sync_opt = 2'b11, count takes cmd_data on the next edge.
- R5: On sync_data_stb with sync_opt = 2'b00, count is not loaded. The status release still happens for a non-broadcast command.
- R6: sync_opt = 2'b01 loads cmd_data only when cmd_data[0] is 0. sync_opt = 2'b10 loads only when cmd_data[0] is 1. Otherwise count is left as it was.
- R7: A synchronize strobe (either kind) with cmd_bcast low produces a one-cycle stat_release pulse two edges after the strobe. This is one edge after any count change. A broadcast strobe produces no pulse.
- R8: A host_util_we sets util_q on the next edge. Writing host_act = 2'b10 makes count equal util_q two edges later. Writing host_act = 2'b01 makes count zero two edges later.
- R9: Writing host_act = 2'b11 copies count into util_q two edges later. act_q shows the written code one edge after the write and 2'b00 one edge after that. Code 2'b00 does nothing.
- R10: If a pending host action executes on the same edge as a synchronize clear or load, the synchronize result is what count holds. The host action is dropped and act_q still returns to 2'b00.
- R11: With match_ie high, match_irq pulses for exactly one cycle on the edge after count first becomes equal to util_q. It does not repeat while they stay equal. With match_ie low, no pulse is produced.
- R12: soft_rst clears count on the next edge, cancels pending actions and status release, and leaves util_q unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, asynchronous assert, active low |
| soft_rst | input | 1 | Terminal soft reset, synchronous |
| tick_en | input | 1 | Count advance enable |
| sync_nodata_stb | input | 1 | Valid synchronize command without data |
| sync_data_stb | input | 1 | Valid synchronize command with data |
| cmd_bcast | input | 1 | Command was broadcast |
| cmd_data | input | 16 | Data word of the synchronize-with-data command |
| sync_opt | input | 2 | Load option for synchronize-with-data |
| host_util_we | input | 1 | Host write to utility register |
| host_util_wdata | input | 16 | Utility register write data |
| host_act_we | input | 1 | Host write to action field |
| host_act | input | 2 | Action code: 00 none, 01 clear, 10 load, 11 capture |
| match_ie | input | 1 | Count-match interrupt enable |
| count | output | 16 | Current time-tag count |
| util_q | output | 16 | Utility register (capture result) |
| act_q | output | 2 | Action field readback |
| match_irq | output | 1 | Count-match interrupt pulse |
| stat_release | output | 1 | Status word may be transmitted |

## Verification
Each result has a fixed delay after its stimulus. A synchronize strobe, a tick, a utility write or a soft reset shows on count or util_q one edge later. Host actions show two edges later, because act_q registers the code first. stat_release and match_irq appear one edge after the count change that caused them. The driver stamps every expected value with the cycle in which it is due, and the monitor compares only in that cycle, just after the edge. A value one cycle early or late is therefore reported.

// File: rtl/ttag_pkg.sv
package ttag_pkg;

  typedef enum logic [1:0] {
    OPT_HOST   = 2'b00,
    OPT_EVEN   = 2'b01,
    OPT_ODD    = 2'b10,
    OPT_ALWAYS = 2'b11
  } ttag_opt_e;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'b00,
    ACT_CLEAR   = 2'b01,
    ACT_LOAD    = 2'b10,
    ACT_CAPTURE = 2'b11
  } ttag_act_e;

endpackage

// File: rtl/ttag_sync_dec.sv
module ttag_sync_dec
  import ttag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         sync_nodata_stb,
  input  logic         sync_data_stb,
  input  logic         cmd_bcast,
  input  logic [W-1:0] cmd_data,
  input  logic [1:0]   sync_opt,
  output logic         sync_clr,
  output logic         sync_ld,
  output logic [W-1:0] sync_val,
  output logic         sync_evt,
  output logic         stat_release
);

  ttag_opt_e opt;
  logic      data_ok;
  logic      pend_d, pend_q;
  logic      rel_d, rel_q;

  // option filter: the lowest data bit selects in the two split modes
  always_comb begin
    opt = ttag_opt_e'(sync_opt);
    unique case (opt)
      OPT_HOST:   data_ok = 1'b0;
      OPT_EVEN:   data_ok = ~cmd_data[0];
      OPT_ODD:    data_ok = cmd_data[0];
      OPT_ALWAYS: data_ok = 1'b1;
      default:    data_ok = 1'b0;
    endcase
  end

  always_comb begin
    sync_clr = sync_nodata_stb & ~soft_rst;
    sync_ld  = sync_data_stb & data_ok & ~sync_nodata_stb & ~soft_rst;
    sync_val = cmd_data;
    sync_evt = sync_clr | sync_ld;
  end

  // stage 1 marks a reply owed; stage 2 releases it once the count has settled
  always_comb begin
    pend_d = (sync_nodata_stb | sync_data_stb) & ~cmd_bcast & ~soft_rst;
    rel_d  = pend_q & ~soft_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      rel_q  <= rel_d;
    end
  end

  assign stat_release = rel_q;

endmodule

// File: rtl/ttag_host_ctl.sv
module ttag_host_ctl
  import ttag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         host_act_we,
  input  logic [1:0]   host_act,
  input  logic         host_util_we,
  input  logic [W-1:0] host_util_wdata,
  input  logic         sync_evt,
  input  logic [W-1:0] count_q,
  output logic [1:0]   act_q,
  output logic [W-1:0] util_q,
  output logic         host_clr,
  output logic         host_ld
);

  ttag_act_e   act_r, act_d;
  logic [W-1:0] util_r, util_d;
  logic         util_en;
  logic         exec_ok;
  logic         do_cap;

  // a pending code runs in the cycle after it is written, unless a sync event takes the counter
  always_comb begin
    exec_ok  = ~soft_rst & ~sync_evt;
    host_clr = exec_ok & (act_r == ACT_CLEAR);
    host_ld  = exec_ok & (act_r == ACT_LOAD);
    do_cap   = exec_ok & (act_r == ACT_CAPTURE);
  end

  always_comb begin
    if (soft_rst)         act_d = ACT_NONE;
    else if (host_act_we) act_d = ttag_act_e'(host_act);
    else                  act_d = ACT_NONE;
  end

  always_comb begin
    util_en = do_cap | host_util_we;
    util_d  = do_cap ? count_q : host_util_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_r <= ACT_NONE;
    else        act_r <= act_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       util_r <= '0;
    else if (util_en) util_r <= util_d;
  end

  assign act_q  = act_r;
  assign util_q = util_r;

endmodule

// File: rtl/ttag_counter.sv
module ttag_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         tick_en,
  input  logic         sync_clr,
  input  logic         sync_ld,
  input  logic [W-1:0] sync_val,
  input  logic         host_clr,
  input  logic         host_ld,
  input  logic [W-1:0] host_val,
  output logic [W-1:0] count_q
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_r, cnt_d;
  logic         cnt_en;

  // priority: soft reset, sync clear, sync load, host clear, host load, tick
  always_comb begin
    cnt_en = soft_rst | sync_clr | sync_ld | host_clr | host_ld | tick_en;
    if (soft_rst | sync_clr) cnt_d = '0;
    else if (sync_ld)        cnt_d = sync_val;
    else if (host_clr)       cnt_d = '0;
    else if (host_ld)        cnt_d = host_val;
    else                     cnt_d = cnt_r + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_r <= '0;
    else if (cnt_en) cnt_r <= cnt_d;
  end

  assign count_q = cnt_r;

endmodule

// File: rtl/ttag_match.sv
module ttag_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         match_ie,
  input  logic [W-1:0] count_q,
  input  logic [W-1:0] util_q,
  output logic         match_irq
);

  logic eq_now;
  logic eq_d, eq_q;
  logic irq_d, irq_q;

  always_comb begin
    eq_now = (count_q == util_q);
    eq_d   = eq_now;
    irq_d  = match_ie & eq_now & ~eq_q;
  end

  // eq_q resets high: the cleared count and cleared utility register are not a new match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q  <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      eq_q  <= eq_d;
      irq_q <= irq_d;
    end
  end

  assign match_irq = irq_q;

endmodule

// File: rtl/ttag_unit.sv
module ttag_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         tick_en,
  input  logic         sync_nodata_stb,
  input  logic         sync_data_stb,
  input  logic         cmd_bcast,
  input  logic [W-1:0] cmd_data,
  input  logic [1:0]   sync_opt,
  input  logic         host_util_we,
  input  logic [W-1:0] host_util_wdata,
  input  logic         host_act_we,
  input  logic [1:0]   host_act,
  input  logic         match_ie,
  output logic [W-1:0] count,
  output logic [W-1:0] util_q,
  output logic [1:0]   act_q,
  output logic         match_irq,
  output logic         stat_release
);

  logic         sync_clr, sync_ld, sync_evt;
  logic [W-1:0] sync_val;
  logic         host_clr, host_ld;
  logic [W-1:0] count_w, util_w;

  ttag_sync_dec #(.W(W)) i_sync (
    .clk             (clk),
    .rst_n           (rst_n),
    .soft_rst        (soft_rst),
    .sync_nodata_stb (sync_nodata_stb),
    .sync_data_stb   (sync_data_stb),
    .cmd_bcast       (cmd_bcast),
    .cmd_data        (cmd_data),
    .sync_opt        (sync_opt),
    .sync_clr        (sync_clr),
    .sync_ld         (sync_ld),
    .sync_val        (sync_val),
    .sync_evt        (sync_evt),
    .stat_release    (stat_release)
  );

  ttag_host_ctl #(.W(W)) i_host (
    .clk             (clk),
    .rst_n           (rst_n),
    .soft_rst        (soft_rst),
    .host_act_we     (host_act_we),
    .host_act        (host_act),
    .host_util_we    (host_util_we),
    .host_util_wdata (host_util_wdata),
    .sync_evt        (sync_evt),
    .count_q         (count_w),
    .act_q           (act_q),
    .util_q          (util_w),
    .host_clr        (host_clr),
    .host_ld         (host_ld)
  );

  ttag_counter #(.W(W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .tick_en  (tick_en),
    .sync_clr (sync_clr),
    .sync_ld  (sync_ld),
    .sync_val (sync_val),
    .host_clr (host_clr),
    .host_ld  (host_ld),
    .host_val (util_w),
    .count_q  (count_w)
  );

  ttag_match #(.W(W)) i_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .match_ie  (match_ie),
    .count_q   (count_w),
    .util_q    (util_w),
    .match_irq (match_irq)
  );

  assign count  = count_w;
  assign util_q = util_w;

endmodule

// File: rtl/ttag_unit_chk.sv
module ttag_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         soft_rst,
  input logic         tick_en,
  input logic         sync_nodata_stb,
  input logic         sync_data_stb,
  input logic         cmd_bcast,
  input logic [W-1:0] cmd_data,
  input logic [1:0]   sync_opt,
  input logic         host_util_we,
  input logic         host_act_we,
  input logic [1:0]   act_q,
  input logic         match_ie,
  input logic [W-1:0] count,
  input logic [W-1:0] util_q,
  input logic         match_irq,
  input logic         stat_release
);

  assert_tick_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !sync_nodata_stb && !sync_data_stb && act_q == 2'b00 && !soft_rst)
    |=> count == $past(count) + W'(1));

  assert_nodata_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_nodata_stb |=> count == '0);

  assert_always_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_data_stb && sync_opt == 2'b11 && !sync_nodata_stb && !soft_rst)
    |=> count == $past(cmd_data));

  assert_stat_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_release |-> $past((sync_nodata_stb || sync_data_stb) && !cmd_bcast, 2));

  assert_stat_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_release && !$past(sync_nodata_stb || sync_data_stb)) |=> !stat_release);

  assert_act_selfclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != 2'b00 && !host_act_we) |=> act_q == 2'b00);

  assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |=> !match_irq);

  assert_irq_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> $past(match_ie));

  assert_util_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !host_util_we) |=> $stable(util_q));

endmodule

bind ttag_unit ttag_unit_chk #(.W(W)) i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .soft_rst        (soft_rst),
  .tick_en         (tick_en),
  .sync_nodata_stb (sync_nodata_stb),
  .sync_data_stb   (sync_data_stb),
  .cmd_bcast       (cmd_bcast),
  .cmd_data        (cmd_data),
  .sync_opt        (sync_opt),
  .host_util_we    (host_util_we),
  .host_act_we     (host_act_we),
  .act_q           (act_q),
  .match_ie        (match_ie),
  .count           (count),
  .util_q          (util_q),
  .match_irq       (match_irq),
  .stat_release    (stat_release)
);

// File: tb/test_ttag_unit.sv
`timescale 1ns/1ps
module test_ttag_unit;

  localparam int W = 16;

  typedef struct {
    int          due;
    int          sel;   // 0 count, 1 util, 2 act, 3 irq, 4 stat
    logic [15:0] val;
    string       tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         soft_rst, tick_en, sync_nodata_stb, sync_data_stb, cmd_bcast;
  logic [W-1:0] cmd_data, host_util_wdata;
  logic [1:0]   sync_opt, host_act;
  logic         host_util_we, host_act_we, match_ie;
  logic [W-1:0] count, util_q;
  logic [1:0]   act_q;
  logic         match_irq, stat_release;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ttag_unit #(.W(W)) i_ttag_unit (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick_en(tick_en),
    .sync_nodata_stb(sync_nodata_stb), .sync_data_stb(sync_data_stb),
    .cmd_bcast(cmd_bcast), .cmd_data(cmd_data), .sync_opt(sync_opt),
    .host_util_we(host_util_we), .host_util_wdata(host_util_wdata),
    .host_act_we(host_act_we), .host_act(host_act), .match_ie(match_ie),
    .count(count), .util_q(util_q), .act_q(act_q),
    .match_irq(match_irq), .stat_release(stat_release)
  );

  function automatic logic [15:0] pick(int sel);
    case (sel)
      0: return count;
      1: return util_q;
      2: return {14'd0, act_q};
      3: return {15'd0, match_irq};
      default: return {15'd0, stat_release};
    endcase
  endfunction

  // driver side: expected item due k edges after the current cycle
  task automatic expect_at(int k, int sel, logic [15:0] v, string tag);
    exp_t e;
    e.due = cyc + k; e.sel = sel; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: samples 1 ns after each edge and retires items due now
  always @(posedge clk) begin
    #1;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        checks++;
        if (pick(sb[i].sel) !== sb[i].val) begin
          failures++;
          $display("FAIL %s sel=%0d cycle=%0d actual=%h expected=%h",
                   sb[i].tag, sb[i].sel, cyc, pick(sb[i].sel), sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic util_write(logic [15:0] v);
    @(negedge clk);
    host_util_we = 1'b1; host_util_wdata = v;
    @(negedge clk);
    host_util_we = 1'b0;
  endtask

  task automatic act_write(logic [1:0] a);
    @(negedge clk);
    host_act_we = 1'b1; host_act = a;
    @(negedge clk);
    host_act_we = 1'b0;
  endtask

  task automatic sync_data(logic [1:0] opt, logic [15:0] d, logic bc);
    sync_opt = opt; cmd_data = d; cmd_bcast = bc; sync_data_stb = 1'b1;
    @(negedge clk);
    sync_data_stb = 1'b0; cmd_bcast = 1'b0;
  endtask

  task automatic ticks(int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (R1..R12 run) actual=%0d cycles expected<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; soft_rst = 0; tick_en = 0; sync_nodata_stb = 0; sync_data_stb = 0;
    cmd_bcast = 0; cmd_data = '0; sync_opt = 2'b00; host_util_we = 0; host_util_wdata = '0;
    host_act_we = 0; host_act = 2'b00; match_ie = 0;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    expect_at(1, 0, 16'h0, "R1 count");
    expect_at(1, 1, 16'h0, "R1 util");
    expect_at(1, 2, 16'h0, "R1 act");
    expect_at(1, 3, 16'h0, "R1 irq");
    expect_at(1, 4, 16'h0, "R1 stat");
    idle(3);

    // R8 utility write, host load
    @(negedge clk); host_util_we = 1; host_util_wdata = 16'h1234;
    expect_at(1, 1, 16'h1234, "R8 util write");
    @(negedge clk); host_util_we = 0;
    host_act_we = 1; host_act = 2'b10;
    expect_at(1, 2, 16'h0002, "R9 act readback");
    expect_at(2, 2, 16'h0000, "R9 act self clear");
    expect_at(2, 0, 16'h1234, "R8 host load");
    @(negedge clk); host_act_we = 0;
    idle(3);

    // R2 ticking
    expect_at(1, 0, 16'h1235, "R2 tick one");
    expect_at(3, 0, 16'h1237, "R2 tick three");
    ticks(3);
    idle(3);

    // R9 capture, R8 clear
    act_write(2'b11);
    expect_at(1, 1, 16'h1237, "R9 capture");
    idle(3);
    act_write(2'b01);
    expect_at(1, 0, 16'h0000, "R8 host clear");
    idle(3);
    // R9 code 00 does nothing
    act_write(2'b00);
    expect_at(1, 0, 16'h0000, "R9 idle code count");
    expect_at(1, 1, 16'h1237, "R9 idle code util");
    idle(3);

    // R2 wrap
    util_write(16'hFFFF);
    act_write(2'b10);
    expect_at(1, 0, 16'hFFFF, "R2 preload");
    idle(3);
    expect_at(1, 0, 16'h0000, "R2 wrap");
    ticks(1);
    idle(3);

    // R3 and R7 sync without data, non-broadcast
    ticks(2);
    idle(2);
    sync_nodata_stb = 1;
    expect_at(1, 0, 16'h0000, "R3 nodata clear");
    expect_at(1, 4, 16'h0, "R7 stat not early");
    expect_at(2, 4, 16'h1, "R7 stat release");
    expect_at(3, 4, 16'h0, "R7 stat one cycle");
    @(negedge clk); sync_nodata_stb = 0;
    idle(4);

    // R4 option 11
    expect_at(1, 0, 16'hABCD, "R4 always load");
    expect_at(2, 4, 16'h1, "R7 stat after load");
    sync_data(2'b11, 16'hABCD, 1'b0);
    idle(4);

    // R5 option 00
    expect_at(1, 0, 16'hABCD, "R5 no load");
    expect_at(2, 4, 16'h1, "R5 stat still sent");
    sync_data(2'b00, 16'h5555, 1'b0);
    idle(4);

    // R6 option 01 / 10
    expect_at(1, 0, 16'h0100, "R6 even loads");
    sync_data(2'b01, 16'h0100, 1'b0);
    idle(3);
    expect_at(1, 0, 16'h0100, "R6 odd rejected by 01");
    sync_data(2'b01, 16'h0201, 1'b0);
    idle(3);
    expect_at(1, 0, 16'h0100, "R6 even rejected by 10");
    sync_data(2'b10, 16'h0202, 1'b0);
    idle(3);
    expect_at(1, 0, 16'h0303, "R6 odd loads");
    sync_data(2'b10, 16'h0303, 1'b0);
    idle(4);

    // R7 broadcast: load, no release
    expect_at(1, 0, 16'h7777, "R7 bcast load");
    expect_at(2, 4, 16'h0, "R7 bcast no stat");
    expect_at(3, 4, 16'h0, "R7 bcast no stat late");
    sync_data(2'b11, 16'h7777, 1'b1);
    idle(4);

    // R10 host load and sync load meet on one edge
    @(negedge clk); host_act_we = 1; host_act = 2'b10;
    @(negedge clk); host_act_we = 0;
    expect_at(1, 0, 16'h2468, "R10 sync wins");
    expect_at(1, 2, 16'h0, "R10 act cleared");
    expect_at(2, 0, 16'h2468, "R10 host dropped");
    sync_data(2'b11, 16'h2468, 1'b0);
    idle(4);

    // R11 match interrupt
    sync_data(2'b11, 16'h002F, 1'b0);
    util_write(16'h0030);
    match_ie = 1;
    idle(3);
    expect_at(1, 0, 16'h0030, "R11 count reaches util");
    expect_at(1, 3, 16'h0, "R11 irq not early");
    expect_at(2, 3, 16'h1, "R11 irq pulse");
    expect_at(3, 3, 16'h0, "R11 irq single");
    expect_at(5, 3, 16'h0, "R11 irq no repeat");
    ticks(1);
    idle(5);
    match_ie = 0;
    sync_data(2'b11, 16'h002F, 1'b0);
    idle(3);
    expect_at(2, 3, 16'h0, "R11 irq masked");
    ticks(1);
    idle(4);

    // R12 soft reset
    @(negedge clk); soft_rst = 1;
    expect_at(1, 0, 16'h0000, "R12 soft clear");
    expect_at(1, 1, 16'h0030, "R12 util kept");
    @(negedge clk); soft_rst = 0;
    expect_at(2, 1, 16'h0030, "R12 util still kept");
    idle(4);

    while (sb.size() != 0) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule